// File: doc/BRIEF.md
# Double-Buffered Parallel DAC Register Front End

This block is the digital front end of a parallel-input digital-to-analog converter. The data word is unsigned straight binary. It holds two registers in series. The first is an input register, written from a parallel data bus under chip select and a read/write strobe. The second is a converter register, loaded from the input register under a separate load strobe. Because of this split, software can stage a new code at any time and commit it to the converter output later. Several channels can also be committed together.

The input register can be read back over the same bus. A read drives the stored word and an output enable, and leaves both registers as they are. An active-low asynchronous reset forces both registers to zero scale or to mid scale. A reset-select input picks which of the two. The block also produces an ideal signed output level computed from the converter code and two reference levels. A surrounding checker can use it in place of the analog ladder.

Both registers behave as level-sensitive latches. They are modelled with a sampling clock. While a strobe condition is present at a rising clock edge, the register follows its source. Once the condition goes away, the register keeps its last value.

Top module: `dac_dbuf_front`

## Requirements
- R1: While `rst_n` is low and `rst_mid` is low, both registers hold code 0x000. Reset takes hold at once on the falling edge of `rst_n`, and `dac_code` and the readback word show 0x000.
- R2: While `rst_n` is low and `rst_mid` is high, both registers hold code 0x800, which is only bit 11 (the MSB) set.
- R3: Reset has priority over every other control. Writes, loads and reads presented while `rst_n` is low leave both registers at the reset code until `rst_n` returns high.
- R4: At a rising clock edge with `cs_n` low and `rd_wr` low, the input register takes the value of `bus_in`. With `ld_n` high, `dac_code` is unchanged.
- R5: At a rising clock edge with `cs_n` high or `rd_wr` high, the input register keeps its value whatever `bus_in` carries.
- R6: At a rising clock edge with `ld_n` low, the converter register takes the input register's value. With `ld_n` high, it holds.
- R7: At a rising clock edge with `cs_n`, `rd_wr` and `ld_n` all low, `bus_in` passes through both registers, so `dac_code` equals `bus_in` after that edge.
- R8: `ld_n` low loads the converter register from the held input register even while `cs_n` is high.
- R9: With `cs_n` low and `rd_wr` high, `bus_oe` is high and `bus_out` carries the input register word. Neither register changes.
- R10: `bus_oe` is low whenever `cs_n` is high or `rd_wr` is low, so the block never drives the bus during a write.
- R11: `ideal_level` equals `REF_LO + floor((REF_HI - REF_LO) * dac_code / 2^CODE_W)`, combinationally from `dac_code`. With the defaults -2500 and 2500 this gives -2500, 0 and 2498 for codes 0x000, 0x800 and 0xFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the level-sensitive registers |
| rst_n | input | 1 | Asynchronous reset, active low |
| rst_mid | input | 1 | Reset code select: 1 gives mid scale, 0 gives zero scale |
| cs_n | input | 1 | Chip select, active low |
| rd_wr | input | 1 | 1 reads the input register, 0 writes it |
| ld_n | input | 1 | Converter register load, active low |
| bus_in | input | CODE_W | Data bus as seen by the block |
| bus_out | output | CODE_W | Readback word for the bus driver |
| bus_oe | output | 1 | Bus driver enable |
| dac_code | output | CODE_W | Converter register code |
| ideal_level | output | LVL_W | Ideal signed output level for the current code |

## Verification
A write into the input register and a load of the converter register can land in the same sampling cycle. In that case the converter register must receive the new bus word, not the word the input register held before. The vector table provokes this by holding chip select, write and load low together on several bus words, including the all-ones and all-zeros codes. The check then looks at `dac_code` one edge later and compares it with the word on the bus. Reset is also driven together with write and load strobes, and the code must stay at the reset value.

// File: rtl/dac_dbuf_pkg.sv
package dac_dbuf_pkg;

    localparam int DEF_CODE_W = 12;
    localparam int DEF_LVL_W  = 16;

    // decoded strobes shared between control and register stages
    typedef struct packed {
        logic wr;   // input register transparent
        logic ld;   // converter register transparent
        logic rd;   // readback driving
    } strobe_t;

endpackage

// File: rtl/dac_dbuf_ctrl.sv
module dac_dbuf_ctrl
    import dac_dbuf_pkg::*;
(
    input  logic    cs_n,
    input  logic    rd_wr,
    input  logic    ld_n,
    output strobe_t strobe
);

    always_comb begin
        strobe    = '0;
        strobe.wr = ~cs_n & ~rd_wr;
        strobe.rd = ~cs_n &  rd_wr;
        strobe.ld = ~ld_n;
    end

endmodule

// File: rtl/dac_dbuf_regs.sv
module dac_dbuf_regs
    import dac_dbuf_pkg::*;
#(
    parameter int CODE_W = DEF_CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_mid,
    input  strobe_t           strobe,
    input  logic [CODE_W-1:0] bus_in,
    output logic [CODE_W-1:0] in_word,
    output logic [CODE_W-1:0] dac_word
);

    localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};

    typedef struct packed {
        logic [CODE_W-1:0] held;
        logic [CODE_W-1:0] conv;
    } regs_t;

    regs_t regs_d, regs_q;
    regs_t rst_val;

    always_comb begin
        rst_val      = '0;
        rst_val.held = rst_mid ? MID_CODE : '0;
        rst_val.conv = rst_mid ? MID_CODE : '0;
    end

    always_comb begin
        regs_d = regs_q;
        if (strobe.wr) begin
            regs_d.held = bus_in;
        end
        // second stage sees the first stage's new value: flow-through
        if (strobe.ld) begin
            regs_d.conv = regs_d.held;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= rst_val;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign in_word  = regs_q.held;
    assign dac_word = regs_q.conv;

endmodule

// File: rtl/dac_dbuf_level.sv
module dac_dbuf_level #(
    parameter int CODE_W = 12,
    parameter int LVL_W  = 16,
    parameter int REF_LO = -2500,
    parameter int REF_HI = 2500
) (
    input  logic [CODE_W-1:0]        code,
    output logic signed [LVL_W-1:0]  level
);

    localparam longint SPAN = longint'(REF_HI) - longint'(REF_LO);

    longint prod;
    longint sum;

    always_comb begin
        prod  = SPAN * longint'({1'b0, code});
        sum   = longint'(REF_LO) + (prod >>> CODE_W);
        level = LVL_W'(sum);
    end

endmodule

// File: rtl/dac_dbuf_front.sv
module dac_dbuf_front
    import dac_dbuf_pkg::*;
#(
    parameter int CODE_W = DEF_CODE_W,
    parameter int LVL_W  = DEF_LVL_W,
    parameter int REF_LO = -2500,
    parameter int REF_HI = 2500
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rst_mid,
    input  logic                    cs_n,
    input  logic                    rd_wr,
    input  logic                    ld_n,
    input  logic [CODE_W-1:0]       bus_in,
    output logic [CODE_W-1:0]       bus_out,
    output logic                    bus_oe,
    output logic [CODE_W-1:0]       dac_code,
    output logic signed [LVL_W-1:0] ideal_level
);

    strobe_t           strobe;
    logic [CODE_W-1:0] in_word;

    dac_dbuf_ctrl u_ctrl (
        .cs_n   (cs_n),
        .rd_wr  (rd_wr),
        .ld_n   (ld_n),
        .strobe (strobe)
    );

    dac_dbuf_regs #(.CODE_W(CODE_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .rst_mid  (rst_mid),
        .strobe   (strobe),
        .bus_in   (bus_in),
        .in_word  (in_word),
        .dac_word (dac_code)
    );

    dac_dbuf_level #(
        .CODE_W (CODE_W),
        .LVL_W  (LVL_W),
        .REF_LO (REF_LO),
        .REF_HI (REF_HI)
    ) u_level (
        .code  (dac_code),
        .level (ideal_level)
    );

    assign bus_out = in_word;
    assign bus_oe  = strobe.rd;

endmodule

// File: rtl/dac_dbuf_front_chk.sv
module dac_dbuf_front_chk #(
    parameter int CODE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rst_mid,
    input logic              cs_n,
    input logic              rd_wr,
    input logic              ld_n,
    input logic [CODE_W-1:0] bus_in,
    input logic [CODE_W-1:0] in_word,
    input logic              bus_oe,
    input logic [CODE_W-1:0] dac_code
);

    localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

    // R1 and R2: the code seen when reset is released is the selected reset code
    p_rst_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> dac_code == ($past(rst_mid) ? MID : '0));

    p_write_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !rd_wr) |=> in_word == $past(bus_in));

    p_input_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_wr) |=> $stable(in_word));

    p_conv_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ld_n |=> $stable(dac_code));

    p_flow_through_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !rd_wr && !ld_n) |=> dac_code == $past(bus_in));

    p_load_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_n && (cs_n || rd_wr)) |=> dac_code == $past(in_word));

    p_read_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && rd_wr) |-> bus_oe);

    p_no_drive_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || !rd_wr) |-> !bus_oe);

endmodule

bind dac_dbuf_front dac_dbuf_front_chk #(.CODE_W(CODE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_mid  (rst_mid),
    .cs_n     (cs_n),
    .rd_wr    (rd_wr),
    .ld_n     (ld_n),
    .bus_in   (bus_in),
    .in_word  (in_word),
    .bus_oe   (bus_oe),
    .dac_code (dac_code)
);

// File: tb/tb_dac_dbuf_front.sv
module tb_dac_dbuf_front;

    localparam int CLK_PERIOD = 10;
    localparam int W  = 12;
    localparam int LW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rst_mid = 1'b0;
    logic          cs_n = 1'b1;
    logic          rd_wr = 1'b1;
    logic          ld_n = 1'b1;
    logic [W-1:0]  bus_in = '0;
    logic [W-1:0]  bus_out;
    logic          bus_oe;
    logic [W-1:0]  dac_code;
    logic signed [LW-1:0] ideal_level;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_dbuf_front dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rst_mid     (rst_mid),
        .cs_n        (cs_n),
        .rd_wr       (rd_wr),
        .ld_n        (ld_n),
        .bus_in      (bus_in),
        .bus_out     (bus_out),
        .bus_oe      (bus_oe),
        .dac_code    (dac_code),
        .ideal_level (ideal_level)
    );

    typedef struct packed {
        logic         cs_n;
        logic         rd_wr;
        logic         ld_n;
        logic [W-1:0] bus;
        logic [W-1:0] exp_dac;
        logic         exp_oe;
        logic [W-1:0] exp_rb;   // checked only when exp_oe
        logic [3:0]   req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 1'b1, 12'hABC, 12'h000, 1'b0, 12'h000, 4'd5},   // R5 idle
        '{1'b0, 1'b0, 1'b1, 12'h123, 12'h000, 1'b0, 12'h000, 4'd4},   // R4 write
        '{1'b0, 1'b1, 1'b1, 12'hFFF, 12'h000, 1'b1, 12'h123, 4'd9},   // R9 read
        '{1'b1, 1'b1, 1'b0, 12'h555, 12'h123, 1'b0, 12'h000, 4'd8},   // R8 load, cs high
        '{1'b1, 1'b0, 1'b1, 12'h777, 12'h123, 1'b0, 12'h000, 4'd10},  // R10 no drive
        '{1'b0, 1'b1, 1'b1, 12'h000, 12'h123, 1'b1, 12'h123, 4'd5},   // R5 no write seen
        '{1'b0, 1'b1, 1'b0, 12'h0F0, 12'h123, 1'b1, 12'h123, 4'd9},   // R9 read+load
        '{1'b0, 1'b0, 1'b0, 12'h9A5, 12'h9A5, 1'b0, 12'h000, 4'd7},   // R7 flow
        '{1'b0, 1'b0, 1'b1, 12'h3C3, 12'h9A5, 1'b0, 12'h000, 4'd6},   // R6 hold
        '{1'b0, 1'b1, 1'b1, 12'h000, 12'h9A5, 1'b1, 12'h3C3, 4'd4},   // R4 readback
        '{1'b1, 1'b1, 1'b0, 12'hAAA, 12'h3C3, 1'b0, 12'h000, 4'd6},   // R6 load
        '{1'b0, 1'b0, 1'b0, 12'hFFF, 12'hFFF, 1'b0, 12'h000, 4'd7},   // R7 all ones
        '{1'b0, 1'b0, 1'b0, 12'h000, 12'h000, 1'b0, 12'h000, 4'd7},   // R7 all zeros
        '{1'b0, 1'b0, 1'b1, 12'h800, 12'h000, 1'b0, 12'h000, 4'd6},   // R6 hold
        '{1'b1, 1'b1, 1'b1, 12'h111, 12'h000, 1'b0, 12'h000, 4'd10},  // R10 idle
        '{1'b0, 1'b1, 1'b1, 12'h222, 12'h000, 1'b1, 12'h800, 4'd5}    // R5 held word
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)",
                     req, act, act, exp, exp);
        end
    endtask

    task automatic drive(input logic c, input logic r, input logic l,
                         input logic [W-1:0] b);
        cs_n = c; rd_wr = r; ld_n = l; bus_in = b;
    endtask

    // drive at falling edge, sample just after the next rising edge
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic flow_word(input logic [W-1:0] b);
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b0, b);
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // reset state, zero-scale select
        #1;
        chk("R1 reset code", int'(dac_code), 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        step();
        chk("R1 code after release", int'(dac_code), 0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i].cs_n, VECS[i].rd_wr, VECS[i].ld_n, VECS[i].bus);
            step();
            chk($sformatf("R%0d vector %0d dac_code", VECS[i].req, i),
                int'(dac_code), int'(VECS[i].exp_dac));
            chk($sformatf("R%0d vector %0d bus_oe", VECS[i].req, i),
                int'(bus_oe), int'(VECS[i].exp_oe));
            if (VECS[i].exp_oe)
                chk($sformatf("R%0d vector %0d bus_out", VECS[i].req, i),
                    int'(bus_out), int'(VECS[i].exp_rb));
        end

        // R11 ideal level at several codes
        flow_word(12'h000); chk("R11 level 0x000", int'(ideal_level), -2500);
        flow_word(12'h800); chk("R11 level 0x800", int'(ideal_level), 0);
        flow_word(12'hFFF); chk("R11 level 0xFFF", int'(ideal_level), 2498);
        flow_word(12'h001); chk("R11 level 0x001", int'(ideal_level), -2499);

        // R2 mid-scale reset, asynchronous, then R3 priority
        flow_word(12'h5A5);
        @(negedge clk);
        drive(1'b1, 1'b1, 1'b1, 12'h000);
        rst_mid = 1'b1;
        #1;
        rst_n = 1'b0;
        #1;
        chk("R2 async mid code", int'(dac_code), 'h800);
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b0, 12'h111);
        step();
        step();
        chk("R3 write+load in reset", int'(dac_code), 'h800);
        @(negedge clk);
        drive(1'b0, 1'b1, 1'b1, 12'h000);
        step();
        chk("R3 readback in reset", int'(bus_out), 'h800);
        @(negedge clk);
        drive(1'b1, 1'b1, 1'b1, 12'h000);
        rst_n = 1'b1;
        step();
        chk("R2 code after release", int'(dac_code), 'h800);
        @(negedge clk);
        drive(1'b0, 1'b1, 1'b1, 12'h000);
        step();
        chk("R2 input register after release", int'(bus_out), 'h800);

        // R1 zero-scale reset from a nonzero code
        flow_word(12'h7E7);
        @(negedge clk);
        drive(1'b1, 1'b1, 1'b1, 12'h000);
        rst_mid = 1'b0;
        #1;
        rst_n = 1'b0;
        #1;
        chk("R1 async zero code", int'(dac_code), 0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b0, 1'b1, 1'b1, 12'hFFF);
        step();
        chk("R1 input register zero", int'(bus_out), 0);
        chk("R1 converter zero", int'(dac_code), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule